// File: doc/BRIEF.md
# Packet Traffic Classifier

This block watches a byte-wide packet stream and sorts each packet into one of four traffic classes. The classes are: web traffic carried by TCP over IPv4, all other TCP over IPv4, UDP over IPv4, and any IPv6 packet. The stream begins at the network-layer header. Each beat carries valid, start-of-packet and end-of-packet flags. While the bytes go by, the block picks out the IP version, the header length, the IPv4 protocol number and the two TCP port numbers. No packet data is stored.

At the last beat of a packet the block decides the class. One cycle later it increments that class's counter and a counter of all accepted packets. The five counters are read through a small read port with one cycle of latency. A synchronous clear input zeroes all of them.

Top module: `traffic_classifier`

## Requirements
- R1: Every accepted packet adds one to the all-packets counter at read index 4, whatever its class.
- R2: The version is bits [7:4] of the first byte of the packet. Version 6 adds one to the counter at index 3. Version 4 goes on to the protocol check. Any other version counts only at index 4.
- R3: For IPv4, the protocol number is byte 9 of the packet. A value of 17 (UDP) counts at index 2. A value of 6 (TCP) goes on to the port check. Any other value, or a header length field (bits [3:0] of byte 0) below 5, counts only at index 4.
- R4: For TCP over IPv4, the transport header starts at byte (header length × 4). Its first four bytes are the source port and then the destination port, each sent high byte first. If either port equals 80 or 443, the packet counts at index 0; otherwise it counts at index 1.
- R5: The class is decided once per packet, on the end-of-packet beat. A packet that ends before every field its class needs has arrived counts only at index 4.
- R6: A beat with valid low changes nothing, whatever its data, start or end flags.
- R7: A valid beat outside a packet that lacks start-of-packet is ignored. A start-of-packet beat in the middle of a packet drops the unfinished packet, which is never counted, and begins parsing afresh.
- R8: `rd_data` shows the counter selected by `rd_idx` one clock after `rd_idx` is applied. Indices 5 to 7 read as zero.
- R9: A clear pulse sets all five counters to zero on the next edge and wins over an increment in the same cycle. Counting resumes from zero after the clear.
- R10: After reset, all five counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of all counters |
| in_valid | input | 1 | Beat valid |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_data | input | 8 | Packet byte |
| rd_idx | input | 3 | Counter select: 0–3 classes, 4 total |
| rd_data | output | 32 | Selected counter, registered |

## Verification
The bench sends packets that end exactly on the last port byte, on the protocol byte, and one byte short of each. A design that decides from the old field values instead of the bytes on the end beat would put the exact-length packets in the total only.

Ports are sent with their bytes swapped (0x5000, 0xBB01), and the port position is moved by using larger header lengths. A design that gets the byte order wrong, or that fixes the transport offset at 20, would report web traffic that is not there or miss web traffic that is. UDP to port 80 must stay UDP, and a single-byte IPv6 packet must still count as IPv6.

Flags are driven during beats with valid low, stray end beats arrive outside a packet, and a start-of-packet beat interrupts an unfinished packet. Any of these, if not ignored, changes a counter.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int NUM_CLS   = 4;
  localparam int NUM_CNT   = NUM_CLS + 1;
  localparam int TOTAL_IDX = NUM_CLS;

  typedef enum logic [1:0] {
    CLS_WEB   = 2'd0,
    CLS_TCP   = 2'd1,
    CLS_UDP   = 2'd2,
    CLS_IPV6  = 2'd3
  } tc_class_e;

  typedef struct packed {
    logic      done;
    logic      cls_ok;
    tc_class_e cls;
  } tc_result_t;
endpackage

// File: rtl/tc_header_parser.sv
module tc_header_parser
  import tc_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic [7:0] in_data,
  output tc_result_t res
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             in_pkt;
  logic [IDX_W-1:0] idx;
  logic [3:0]       ver, ihl;
  logic [7:0]       proto;
  logic [31:0]      ports;
  logic             hv, hp, hports;

  logic             beat;
  logic [IDX_W-1:0] cur, off;
  logic [3:0]       n_ver, n_ihl;
  logic [7:0]       n_proto;
  logic [31:0]      n_ports;
  logic             n_hv, n_hp, n_hports;
  logic             web, dec_ok;
  tc_class_e        dec_cls;

  assign beat = in_valid && (in_sop || in_pkt);
  assign cur  = in_sop ? '0 : idx;

  // field capture including the byte on the current beat
  always_comb begin
    n_ver    = ver;
    n_ihl    = ihl;
    n_proto  = proto;
    n_ports  = ports;
    n_hv     = in_sop ? 1'b0 : hv;
    n_hp     = in_sop ? 1'b0 : hp;
    n_hports = in_sop ? 1'b0 : hports;
    if (cur == '0) begin
      n_ver = in_data[7:4];
      n_ihl = in_data[3:0];
      n_hv  = 1'b1;
    end
    if (cur == IDX_W'(9)) begin
      n_proto = in_data;
      n_hp    = 1'b1;
    end
    off = IDX_W'({n_ihl, 2'b00});
    if (cur == off)                n_ports[31:24] = in_data;
    if (cur == off + IDX_W'(1))    n_ports[23:16] = in_data;
    if (cur == off + IDX_W'(2))    n_ports[15:8]  = in_data;
    if (cur == off + IDX_W'(3)) begin
      n_ports[7:0] = in_data;
      n_hports     = 1'b1;
    end
  end

  assign web = (n_ports[31:16] == 16'd80) || (n_ports[31:16] == 16'd443) ||
               (n_ports[15:0]  == 16'd80) || (n_ports[15:0]  == 16'd443);

  // class decision from the fields known at this beat
  always_comb begin
    dec_ok  = 1'b0;
    dec_cls = CLS_WEB;
    if (n_hv && n_ver == 4'd6) begin
      dec_ok  = 1'b1;
      dec_cls = CLS_IPV6;
    end else if (n_hv && n_ver == 4'd4 && n_ihl >= 4'd5 && n_hp) begin
      if (n_proto == 8'd17) begin
        dec_ok  = 1'b1;
        dec_cls = CLS_UDP;
      end else if (n_proto == 8'd6 && n_hports) begin
        dec_ok  = 1'b1;
        dec_cls = web ? CLS_WEB : CLS_TCP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt <= 1'b0;
      idx    <= '0;
      ver    <= '0;
      ihl    <= '0;
      proto  <= '0;
      ports  <= '0;
      hv     <= 1'b0;
      hp     <= 1'b0;
      hports <= 1'b0;
      res    <= '0;
    end else begin
      res.done   <= beat && in_eop;
      res.cls_ok <= dec_ok;
      res.cls    <= dec_cls;
      if (beat) begin
        in_pkt <= !in_eop;
        idx    <= (cur == IDX_MAX) ? cur : cur + IDX_W'(1);
        ver    <= n_ver;
        ihl    <= n_ihl;
        proto  <= n_proto;
        ports  <= n_ports;
        hv     <= n_hv;
        hp     <= n_hp;
        hports <= n_hports;
      end
    end
  end

  // R7: a start beat restarts byte numbering
  a_r7_sop_restart: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop) |=> (idx == IDX_W'(1)));

  // R5: a result appears only after an accepted end beat
  a_r5_done_after_eop: assert property (@(posedge clk) disable iff (rst)
    res.done |-> $past(in_valid && in_eop));

  // R6: a beat with valid low leaves the byte position alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(idx));
endmodule

// File: rtl/tc_counter_bank.sv
module tc_counter_bank
  import tc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  tc_result_t       res,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_data
);
  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic [NUM_CNT-1:0] inc;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    if (i == TOTAL_IDX) begin : g_total
      assign inc[i] = res.done;
    end else begin : g_class
      assign inc[i] = res.done && res.cls_ok && (res.cls == tc_class_e'(i));
    end

    always_ff @(posedge clk) begin
      if (rst || clear)
        cnt[i] <= '0;
      else if (inc[i])
        cnt[i] <= cnt[i] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_idx < SEL_W'(NUM_CNT))
      rd_data <= cnt[rd_idx];
    else
      rd_data <= '0;
  end

  // R1: the total advances by exactly one per finished packet
  a_r1_total_step: assert property (@(posedge clk) disable iff (rst)
    (inc[TOTAL_IDX] && !clear) |=> (cnt[TOTAL_IDX] == $past(cnt[TOTAL_IDX]) + CNT_W'(1)));

  // R5: at most one class counter moves per packet
  a_r5_single_class: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inc[NUM_CLS-1:0]));

  // R9: clear empties the counters on the next edge
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt[TOTAL_IDX] == '0 && cnt[0] == '0 && cnt[NUM_CLS-1] == '0));

  // R8: unused indices read as zero
  a_r8_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_idx >= SEL_W'(NUM_CNT)) |=> (rd_data == '0));
endmodule

// File: rtl/traffic_classifier.sv
module traffic_classifier
  import tc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int IDX_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [7:0]       in_data,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_data
);
  tc_result_t res;

  tc_header_parser #(.IDX_W(IDX_W)) u_parser (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .in_data  (in_data),
    .res      (res)
  );

  tc_counter_bank #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_counters (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .res     (res),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );
endmodule

// File: tb/traffic_classifier_test.sv
module traffic_classifier_test;
  logic        clk = 1'b0;
  logic        rst, clear, in_valid, in_sop, in_eop;
  logic [7:0]  in_data;
  logic [2:0]  rd_idx;
  logic [31:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  int unsigned expc [5];

  always #2 clk = ~clk;

  traffic_classifier uut (
    .clk(clk), .rst(rst), .clear(clear), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // {ver, ihl, proto, sport, dport, length, expected index}
  localparam int NV = 15;
  localparam logic [58:0] VEC [NV] = '{
    {4'd4, 4'd5, 8'd6,  16'd1234,  16'd80,    8'd40, 3'd0},
    {4'd4, 4'd5, 8'd6,  16'd443,   16'd5000,  8'd40, 3'd0},
    {4'd4, 4'd5, 8'd6,  16'd1234,  16'd22,    8'd40, 3'd1},
    {4'd4, 4'd7, 8'd6,  16'd999,   16'd80,    8'd48, 3'd0},
    {4'd4, 4'd5, 8'd17, 16'd53,    16'd80,    8'd30, 3'd2},
    {4'd6, 4'd0, 8'd0,  16'd0,     16'd0,     8'd60, 3'd3},
    {4'd4, 4'd5, 8'd1,  16'd80,    16'd80,    8'd40, 3'd4},
    {4'd5, 4'd5, 8'd6,  16'd80,    16'd80,    8'd40, 3'd4},
    {4'd4, 4'd5, 8'd6,  16'd80,    16'd80,    8'd23, 3'd4},
    {4'd4, 4'd5, 8'd6,  16'd7,     16'd443,   8'd24, 3'd0},
    {4'd4, 4'd5, 8'd17, 16'd1,     16'd2,     8'd10, 3'd2},
    {4'd4, 4'd5, 8'd17, 16'd1,     16'd2,     8'd9,  3'd4},
    {4'd4, 4'd6, 8'd6,  16'h5000,  16'hBB01,  8'd28, 3'd1},
    {4'd6, 4'd0, 8'd0,  16'd0,     16'd0,     8'd1,  3'd3},
    {4'd4, 4'd3, 8'd6,  16'd80,    16'd80,    8'd40, 3'd4}
  };

  function automatic logic [7:0] pkt_byte(input logic [3:0] ver, ihl, input logic [7:0] proto,
                                          input logic [15:0] sp, dp, input int i);
    int off = int'(ihl) * 4;
    if (i == 0)            return {ver, ihl};
    else if (i == off)     return sp[15:8];
    else if (i == off + 1) return sp[7:0];
    else if (i == off + 2) return dp[15:8];
    else if (i == off + 3) return dp[7:0];
    else if (i == 9)       return proto;
    else                   return 8'hA5 ^ 8'(i);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'h00;
  endtask

  task automatic read_cnt(input int idx, output logic [31:0] v);
    @(negedge clk); rd_idx = 3'(idx);
    @(negedge clk); v = rd_data;
  endtask

  task automatic send_pkt(input logic [3:0] ver, ihl, input logic [7:0] proto,
                          input logic [15:0] sp, dp, input int len, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && i > 0) begin
        // R6: flags and data on a beat with valid low
        @(negedge clk); in_valid = 1'b0; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'h60;
      end
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == len - 1);
      in_data  = pkt_byte(ver, ihl, proto, sp, dp, i);
    end
    @(negedge clk); idle();
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int k = 0; k < 5; k++) begin
      read_cnt(k, v);
      check($sformatf("%s idx %0d", tag, k), v, expc[k]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    string tag;
    rst = 1'b1; clear = 1'b0; rd_idx = '0; idle();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) expc[k] = 0;

    // R10: reset state
    check_all("R10 reset");

    // table walk: R1..R5, with gaps on odd vectors (R6)
    for (int n = 0; n < NV; n++) begin
      logic [58:0] t = VEC[n];
      int e = int'(t[2:0]);
      send_pkt(t[58:55], t[54:51], t[50:43], t[42:27], t[26:11], int'(t[10:3]), n[0]);
      expc[4]++;
      if (e < 4) expc[e]++;
      case (e)
        0, 1:    tag = "R4";
        2:       tag = "R3";
        3:       tag = "R2";
        default: tag = "R5";
      endcase
      if (e < 4) begin
        read_cnt(e, v);
        check($sformatf("%s vector %0d", tag, n), v, expc[e]);
      end
      read_cnt(4, v);
      check($sformatf("R1 vector %0d", n), v, expc[4]);
    end
    check_all("R6 after table");

    // R7: stray beats outside a packet
    @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b1; in_data = 8'h60;
    @(negedge clk); in_eop = 1'b0; in_data = 8'h45;
    @(negedge clk); in_eop = 1'b1;
    @(negedge clk); idle();
    check_all("R7 stray");

    // R7: an unfinished TCP web packet interrupted by an IPv6 start
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = 1'b0;
      in_data  = pkt_byte(4'd4, 4'd5, 8'd6, 16'd80, 16'd80, i);
    end
    send_pkt(4'd6, 4'd0, 8'd0, 16'd0, 16'd0, 5, 1'b0);
    expc[4]++; expc[3]++;
    check_all("R7 restart");

    // R8: out-of-range indices
    for (int k = 5; k < 8; k++) begin
      read_cnt(k, v);
      check($sformatf("R8 idx %0d", k), v, 32'd0);
    end

    // R9: clear, then count again
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    for (int k = 0; k < 5; k++) expc[k] = 0;
    check_all("R9 clear");
    send_pkt(4'd4, 4'd5, 8'd17, 16'd5, 16'd6, 20, 1'b0);
    expc[4]++; expc[2]++;
    check_all("R9 after clear");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule